// File: doc/BRIEF.md
# Reloadable Watchdog Timer with Halt and Two-Stage Timeout

A countdown watchdog sitting behind a small register port (address, write data, write strobe, combinational read data). Software programs an initial count, releases the halt bit to let the counter run, and keeps the system alive by writing to the reload address before the count runs out. The counter steps down once for every pulse on the `tick` input, which is produced elsewhere from a slow timebase (nominally 0.6 s per tick, so a timeout of S seconds needs S*10/6 ticks).

Running out of count is handled in two stages. The first expiry raises a timeout flag and reloads the counter automatically, which gives software a second window to react. A second expiry while that flag is still set raises a second flag and asserts a sticky system reset request, unless no-reboot is in force. No-reboot is the OR of a software control bit and a hardware lock input, and the control register reads back the OR, so software can tell when it failed to clear it.

Register offsets (16-bit data): 0x00 reload / live count, 0x04 first-stage status, 0x06 second-stage status, 0x08 control, 0x12 initial value. Other offsets in the 32-byte window read as zero and ignore writes.

Top module: `keepalive_wdt`

## Requirements
- R1: After reset the halt bit is 1, the initial value is 4, the count is 4, both status registers read 0 and `sys_rst_req` is 0.
- R2: A write to 0x12 whose low CNT_W bits are 0 to 3 is ignored and the previous value is kept; any other write stores all 16 bits, and the upper bits read back as written.
- R3: Any write to 0x00 loads the count from the initial value on the next edge; a read of 0x00 returns the live count in the low CNT_W bits, zero above.
- R4: Control bit 11 is the halt bit and reads back as written; while it is 1 ticks are ignored, while it is 0 each tick with a non-zero count lowers the count by one.
- R5: A tick that finds the running count at 0 is an expiry: the count reloads from the initial value and, if status 0x04 bit 3 is clear, that bit is set.
- R6: An expiry while status 0x04 bit 3 is already set sets status 0x06 bit 1 and asserts `sys_rst_req`, unless no-reboot is held at that moment.
- R7: No-reboot is held when control bit 1 is 1 or `nr_lock` is 1; control bit 1 reads back the held value, not the written one.
- R8: Status bits are write-one-to-clear; writing 0 to a status bit leaves it unchanged (writing 3 to 0x06 clears it).
- R9: A reload write in the same cycle as a tick takes priority: the count loads the initial value and no decrement or expiry happens.
- R10: Once asserted, `sys_rst_req` stays 1 until the block is reset, regardless of status clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W (5) | Register byte offset |
| bus_wdata | input | DATA_W (16) | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | DATA_W (16) | Read data for `bus_addr`, combinational |
| tick | input | 1 | One-cycle count pulse from the prescaler |
| nr_lock | input | 1 | Forces no-reboot on when 1 |
| sys_rst_req | output | 1 | Sticky system reset request |

## Verification
The assertions assume `tick` and the write strobe are clean single-cycle levels sampled on the rising edge and that a status clear never collides with the expiry that would set the same bit; where both happen, setting wins and the properties still hold. The random stimulus uses small initial values so that both expiry stages are reached often, biases the halt bit towards running, and toggles `nr_lock` and the no-reboot bit rarely so that gated and ungated second expiries both occur. Directed steps cover the rejected initial values, a reload coinciding with a tick, and a reset request that survives a status clear.

// File: rtl/keepalive_wdt.sv
module keepalive_wdt #(
  parameter int CNT_W  = 10,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick,
  input  logic              nr_lock,
  output logic              sys_rst_req
);
  localparam int HI_W = DATA_W - CNT_W;
  localparam logic [ADDR_W-1:0] A_RELOAD = ADDR_W'(5'h00);
  localparam logic [ADDR_W-1:0] A_STS1   = ADDR_W'(5'h04);
  localparam logic [ADDR_W-1:0] A_STS2   = ADDR_W'(5'h06);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(5'h08);
  localparam logic [ADDR_W-1:0] A_INIT   = ADDR_W'(5'h12);
  localparam int HALT_POS = 11;
  localparam int NR_POS   = 1;
  localparam int TO1_POS  = 3;
  localparam int TO2_POS  = 1;
  localparam logic [CNT_W-1:0] MIN_INIT = CNT_W'(4);

  logic [CNT_W-1:0] cnt_q, init_q;
  logic [HI_W-1:0]  init_hi_q;
  logic             halt_q, nr_q, to1_q, to2_q, req_q;

  wire sel_reload = bus_we && (bus_addr == A_RELOAD);
  wire sel_sts1   = bus_we && (bus_addr == A_STS1);
  wire sel_sts2   = bus_we && (bus_addr == A_STS2);
  wire sel_ctrl   = bus_we && (bus_addr == A_CTRL);
  wire sel_init   = bus_we && (bus_addr == A_INIT);
  wire init_ok    = bus_wdata[CNT_W-1:0] >= MIN_INIT;
  wire nr_held    = nr_q | nr_lock;
  wire run        = tick & ~halt_q & ~sel_reload;
  wire expire     = run && (cnt_q == '0);

  assign sys_rst_req = req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= MIN_INIT;
      init_q    <= MIN_INIT;
      init_hi_q <= '0;
      halt_q    <= 1'b1;
      nr_q      <= 1'b0;
      to1_q     <= 1'b0;
      to2_q     <= 1'b0;
      req_q     <= 1'b0;
    end else begin
      if (sel_init && init_ok) begin
        init_q    <= bus_wdata[CNT_W-1:0];
        init_hi_q <= bus_wdata[DATA_W-1:CNT_W];
      end
      if (sel_ctrl) begin
        halt_q <= bus_wdata[HALT_POS];
        nr_q   <= bus_wdata[NR_POS];
      end
      if (sel_reload || expire) cnt_q <= init_q;
      else if (run)             cnt_q <= cnt_q - CNT_W'(1);
      if (expire && !to1_q)                    to1_q <= 1'b1;
      else if (sel_sts1 && bus_wdata[TO1_POS]) to1_q <= 1'b0;
      if (expire && to1_q)                     to2_q <= 1'b1;
      else if (sel_sts2 && bus_wdata[TO2_POS]) to2_q <= 1'b0;
      if (expire && to1_q && !nr_held)         req_q <= 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_RELOAD: bus_rdata[CNT_W-1:0] = cnt_q;
      A_STS1:   bus_rdata[TO1_POS] = to1_q;
      A_STS2:   bus_rdata[TO2_POS] = to2_q;
      A_CTRL: begin
        bus_rdata[HALT_POS] = halt_q;
        bus_rdata[NR_POS]   = nr_held;
      end
      A_INIT:   bus_rdata = {init_hi_q, init_q};
      default:  bus_rdata = '0;
    endcase
  end

  p_init_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
    init_q >= MIN_INIT);
  p_reload_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_reload |=> cnt_q == $past(init_q));
  p_halt_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && !sel_reload) |=> $stable(cnt_q));
  p_step_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !halt_q && !sel_reload && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CNT_W'(1));
  p_expiry_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !halt_q && !sel_reload && cnt_q == '0) |=> cnt_q == $past(init_q));
  p_req_second_stage_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_req) |-> $past(to1_q) && $past(tick));
  p_req_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_req) |-> !$past(nr_q) && !$past(nr_lock));
  p_req_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |=> sys_rst_req);
endmodule

// File: tb/keepalive_wdt_tb_top.sv
`timescale 1ns/1ps
module keepalive_wdt_tb_top;
  localparam int CW = 10;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic we = 1'b0, tick = 1'b0, lock = 1'b0, req;
  int checks = 0, errors = 0, cycles = 0;

  logic [CW-1:0] m_cnt, m_init;
  logic [15-CW:0] m_hi;
  logic m_halt, m_nr, m_to1, m_to2, m_req;

  always #2.5 clk = ~clk;

  keepalive_wdt dut_i (.clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata),
    .bus_we(we), .bus_rdata(rdata), .tick(tick), .nr_lock(lock), .sys_rst_req(req));

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000 (all requirements)", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [15:0] model_rd(input logic [4:0] a);
    case (a)
      5'h00: return {{(16-CW){1'b0}}, m_cnt};
      5'h04: return {12'd0, m_to1, 3'd0};
      5'h06: return {14'd0, m_to2, 1'b0};
      5'h08: return {4'd0, m_halt, 9'd0, m_nr | lock, 1'b0};
      5'h12: return {m_hi, m_init};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic check(input string req_tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%04h expected=0x%04h", req_tag, got, exp);
    end
  endtask

  task automatic model_reset();
    m_cnt = CW'(4); m_init = CW'(4); m_hi = '0; m_halt = 1'b1;
    m_nr = 1'b0; m_to1 = 1'b0; m_to2 = 1'b0; m_req = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; we = 1'b0; tick = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  task automatic step(input logic w, input logic [4:0] a, input logic [15:0] d, input logic t);
    logic o_halt, o_nr, o_to1;
    logic [CW-1:0] o_init;
    @(negedge clk); we = w; addr = a; wdata = d; tick = t;
    @(posedge clk);
    o_halt = m_halt; o_nr = m_nr | lock; o_to1 = m_to1; o_init = m_init;
    if (w) begin
      case (a)
        5'h04: if (d[3]) m_to1 = 1'b0;
        5'h06: if (d[1]) m_to2 = 1'b0;
        5'h08: begin m_halt = d[11]; m_nr = d[1]; end
        5'h12: if (d[CW-1:0] >= CW'(4)) begin m_init = d[CW-1:0]; m_hi = d[15:CW]; end
        default: ;
      endcase
    end
    if (w && a == 5'h00) m_cnt = o_init;
    else if (t && !o_halt) begin
      if (m_cnt == '0) begin
        m_cnt = o_init;
        if (o_to1) begin
          m_to2 = 1'b1;
          if (!o_nr) m_req = 1'b1;
        end else m_to1 = 1'b1;
      end else m_cnt = m_cnt - CW'(1);
    end
    #1; we = 1'b0; tick = 1'b0;
  endtask

  task automatic rd(input string req_tag, input logic [4:0] a, input logic [15:0] exp);
    @(negedge clk); addr = a; #1;
    check(req_tag, rdata, exp);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    do_reset();
    // R1 reset state
    rd("R1", 5'h00, 16'h0004);
    rd("R1", 5'h08, 16'h0800);
    rd("R1", 5'h04, 16'h0000);
    rd("R1", 5'h06, 16'h0000);
    rd("R1", 5'h12, 16'h0004);
    check("R1", {15'd0, req}, 16'h0000);
    // R2 rejected and accepted initial values
    step(1, 5'h12, 16'h0002, 0);
    rd("R2", 5'h12, 16'h0004);
    step(1, 5'h12, 16'hFC03, 0);
    rd("R2", 5'h12, 16'h0004);
    step(1, 5'h12, 16'hFC0A, 0);
    rd("R2", 5'h12, 16'hFC0A);
    rd("R3", 5'h00, 16'h0004);
    // R4 halted counter ignores ticks
    repeat (3) step(0, 5'h00, 16'h0000, 1);
    rd("R4", 5'h00, 16'h0004);
    step(1, 5'h00, 16'h1234, 0);
    rd("R3", 5'h00, 16'h000A);
    step(1, 5'h08, 16'h0000, 0);
    rd("R4", 5'h08, 16'h0000);
    repeat (3) step(0, 5'h00, 16'h0000, 1);
    rd("R4", 5'h00, 16'h0007);
    // R9 reload beats tick
    step(1, 5'h00, 16'h0000, 1);
    rd("R9", 5'h00, 16'h000A);
    // R5 first expiry
    repeat (10) step(0, 5'h00, 16'h0000, 1);
    rd("R5", 5'h00, 16'h0000);
    rd("R5", 5'h04, 16'h0000);
    step(0, 5'h00, 16'h0000, 1);
    rd("R5", 5'h04, 16'h0008);
    rd("R5", 5'h00, 16'h000A);
    check("R5", {15'd0, req}, 16'h0000);
    // R8 writing zero leaves status
    step(1, 5'h04, 16'h0000, 0);
    rd("R8", 5'h04, 16'h0008);
    // R6 second expiry requests reset
    repeat (11) step(0, 5'h00, 16'h0000, 1);
    rd("R6", 5'h06, 16'h0002);
    check("R6", {15'd0, req}, 16'h0001);
    step(1, 5'h06, 16'h0003, 0);
    rd("R8", 5'h06, 16'h0000);
    step(1, 5'h04, 16'h0008, 0);
    rd("R8", 5'h04, 16'h0000);
    check("R10", {15'd0, req}, 16'h0001);
    // R7 no-reboot gates the request
    do_reset();
    step(1, 5'h08, 16'h0002, 0);
    rd("R7", 5'h08, 16'h0002);
    repeat (10) step(0, 5'h00, 16'h0000, 1);
    rd("R6", 5'h06, 16'h0002);
    check("R7", {15'd0, req}, 16'h0000);
    @(negedge clk); lock = 1'b1;
    step(1, 5'h08, 16'h0000, 0);
    rd("R7", 5'h08, 16'h0002);
    @(negedge clk); lock = 1'b0;
    rd("R7", 5'h08, 16'h0000);
    // random phase against the bench model
    do_reset();
    for (int i = 0; i < 4000; i++) begin
      int op;
      logic [15:0] d;
      logic [4:0] a;
      logic [4:0] ra;
      op = $urandom % 10;
      d = 16'($urandom);
      if ($urandom % 50 == 0) begin @(negedge clk); lock = ~lock; end
      case (op)
        0: begin a = 5'h12; d[CW-1:0] = CW'($urandom % 24); end
        1: a = 5'h00;
        2: begin a = 5'h08; d[11] = ($urandom % 4 == 0); d[1] = ($urandom % 3 == 0); end
        3: a = 5'h04;
        4: a = 5'h06;
        default: a = 5'h00;
      endcase
      step(op < 5, a, d, 1'($urandom % 2));
      check("R6", {15'd0, req}, {15'd0, m_req});
      case ($urandom % 5)
        0: ra = 5'h00; 1: ra = 5'h04; 2: ra = 5'h06; 3: ra = 5'h08;
        default: ra = 5'h12;
      endcase
      rd((ra == 5'h00) ? "R3" : (ra == 5'h12) ? "R2" : (ra == 5'h08) ? "R7" : "R5",
         ra, model_rd(ra));
      if (i % 1000 == 999) do_reset();
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule